// File: doc/BRIEF.md
# Symmetric Grey-Level Pair Count Accumulator

This block builds a symmetric co-occurrence count matrix for one pixel orientation. An upstream neighbourhood unit presents one grey-level pair per clock. For every accepted pair the block adds one to the entry at row `i`, column `j` and one to the mirror entry at row `j`, column `i`. The counts sit in an on-chip synchronous RAM. A read-modify-write pipeline updates that RAM and forwards its own last write, so bursts of identical pairs count correctly at full rate. Each entry is a 16-bit count that saturates.

A frame has three phases. First, a clear sequence writes zero to every RAM word, one word per cycle. During that sequence `busy` is high and `ready` is low. Next comes the accumulate phase, with `ready` high. A `frame_done` pulse ends it. After a single flush cycle, `scan_ok` rises and a feature unit downstream can read any entry through the scan port. A running total of all matrix contributions is exported, and software divides by it to normalise. `clear_start` begins the next frame.

Top module: `glcm_sym_accum`

## Requirements
- R1: Reset enters the clear sequence. While it runs, `busy` is 1 and `ready` is 0. It lasts exactly 4^PIX_W cycles after reset is released (4096 by default), and then `ready` is 1. At most one of `ready`, `busy` and `scan_ok` is high in any cycle.
- R2: A pair with `pair_i != pair_j` is accepted in a cycle where `ready`=1, `pair_valid`=1 and `clear_start`=0. Each accepted pair adds 1 to entry (`pair_i`, `pair_j`) and adds 1 to entry (`pair_j`, `pair_i`).
- R3: A pair with `pair_i == pair_j` adds 2 to the single diagonal entry.
- R4: One pair can be accepted in every cycle. Consecutive pairs that hit the same entry all count, with none lost.
- R5: An entry stops at 65535 (all ones) and does not wrap.
- R6: `total_count` rises by 2 for each accepted pair, in the cycle after acceptance. It therefore equals the sum of all matrix entries while no entry has saturated.
- R7: Pairs presented while `ready`=0 change neither the matrix nor `total_count`. This covers the clear sequence, the flush cycle and the scan phase.
- R8: When `frame_done` is high in a cycle where `ready`=1, the pair in that same cycle is still accepted. In the next cycle `ready` and `scan_ok` are both 0. One cycle after that, `scan_ok` is 1.
- R9: While `scan_ok`=1, `scan_data` holds the entry addressed by `scan_addr` one cycle earlier. The row is in the upper PIX_W bits of `scan_addr` and the column is in the lower PIX_W bits.
- R10: `clear_start`, given after a frame, zeroes every entry. It also sets `total_count` to 0 in the same cycle that `busy` rises.
- R11: The default PIX_W=6 gives a 64x64 matrix, and PIX_W=8 gives a 256x256 matrix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_start | input | 1 | Start zeroing the matrix for a new frame |
| pair_valid | input | 1 | A pixel pair is presented |
| pair_i | input | PIX_W | Grey level of the centre pixel |
| pair_j | input | PIX_W | Grey level of the neighbour pixel |
| frame_done | input | 1 | The last pair of the frame is presented |
| scan_addr | input | 2*PIX_W | Scan address: {row, column} |
| ready | output | 1 | Pairs are being accepted |
| busy | output | 1 | Clear sequence running |
| scan_ok | output | 1 | Matrix complete; scan port valid |
| scan_data | output | CNT_W | Entry read at the previous cycle's `scan_addr` |
| total_count | output | TOT_W | Sum of all contributions of the frame |

## Verification
The results become visible at different times, and the bench samples each one at its own cycle. `total_count` moves one cycle after a pair is accepted, so the bench reads it at the falling edge after that acceptance edge. The status outputs take two cycles from `frame_done` to `scan_ok`, and the bench checks both the intermediate cycle and the final one. A matrix entry can only be observed through the scan port, which has a registered read with one cycle of latency. The bench therefore drives `scan_addr` at a falling edge and compares `scan_data` one full cycle later, against a reference matrix built by its own model of the symmetric, saturating update.

// File: rtl/glcm_pkg.sv
package glcm_pkg;

    typedef enum logic [1:0] {
        ST_CLEAR = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } acc_state_e;

    localparam logic [1:0] STEP_OFFDIAG = 2'd1;
    localparam logic [1:0] STEP_DIAG    = 2'd2;

endpackage

// File: rtl/coocc_addr_fold.sv
// Maps an unordered grey-level pair onto one canonical RAM word.
// The smaller level becomes the row, so (a,b) and (b,a) share storage.
module coocc_addr_fold #(
    parameter int PIX_W = 6
) (
    input  logic [PIX_W-1:0]   lvl_a,
    input  logic [PIX_W-1:0]   lvl_b,
    output logic [2*PIX_W-1:0] word_addr
);
    always_comb begin
        if (lvl_a <= lvl_b) begin
            word_addr = {lvl_a, lvl_b};
        end else begin
            word_addr = {lvl_b, lvl_a};
        end
    end
endmodule

// File: rtl/sat_inc.sv
// Adds a small step to a count; optionally clips at the all-ones value.
module sat_inc #(
    parameter int CNT_W    = 16,
    parameter bit SATURATE = 1'b1
) (
    input  logic [CNT_W-1:0] base,
    input  logic [1:0]       step,
    output logic [CNT_W-1:0] result
);
    logic [CNT_W:0] wide_sum;

    assign wide_sum = {1'b0, base} + {{(CNT_W-1){1'b0}}, step};

    generate
        if (SATURATE) begin : g_clip
            assign result = wide_sum[CNT_W] ? {CNT_W{1'b1}} : wide_sum[CNT_W-1:0];
        end else begin : g_wrap
            assign result = wide_sum[CNT_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/glcm_count_ram.sv
// Simple dual-port synchronous RAM: one write port, one registered read port.
// A read of the word being written in the same cycle returns the old value.
module glcm_count_ram #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
        rdata <= mem[raddr];
    end
endmodule

// File: rtl/glcm_sym_accum.sv
module glcm_sym_accum
    import glcm_pkg::*;
#(
    parameter int PIX_W  = 6,
    parameter int CNT_W  = 16,
    parameter int TOT_W  = 32,
    parameter bit SAT_EN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_start,
    input  logic               pair_valid,
    input  logic [PIX_W-1:0]   pair_i,
    input  logic [PIX_W-1:0]   pair_j,
    input  logic               frame_done,
    input  logic [2*PIX_W-1:0] scan_addr,
    output logic               ready,
    output logic               busy,
    output logic               scan_ok,
    output logic [CNT_W-1:0]   scan_data,
    output logic [TOT_W-1:0]   total_count
);
    localparam int AW    = 2 * PIX_W;
    localparam int DEPTH = 1 << AW;
    localparam logic [AW-1:0]    LAST_ADDR = AW'(DEPTH - 1);
    localparam logic [TOT_W-1:0] TOT_STEP  = TOT_W'(2);

    typedef struct packed {
        acc_state_e       st;
        logic [AW-1:0]    clr_addr;
        logic             s1_v;
        logic [AW-1:0]    s1_addr;
        logic [1:0]       s1_step;
        logic             wb_v;
        logic [AW-1:0]    wb_addr;
        logic [CNT_W-1:0] wb_data;
        logic [TOT_W-1:0] total;
    } acc_regs_t;

    acc_regs_t q, d;

    logic [AW-1:0]    in_addr;
    logic [AW-1:0]    sc_addr;
    logic             accept;
    logic [AW-1:0]    ram_raddr;
    logic [CNT_W-1:0] ram_rdata;
    logic             ram_we;
    logic [AW-1:0]    ram_waddr;
    logic [CNT_W-1:0] ram_wdata;
    logic [CNT_W-1:0] upd_base;
    logic [CNT_W-1:0] upd_value;

    // Canonical word of the incoming pair and of the scan request.
    coocc_addr_fold #(.PIX_W(PIX_W)) u_fold_in (
        .lvl_a     (pair_i),
        .lvl_b     (pair_j),
        .word_addr (in_addr)
    );

    coocc_addr_fold #(.PIX_W(PIX_W)) u_fold_scan (
        .lvl_a     (scan_addr[AW-1:PIX_W]),
        .lvl_b     (scan_addr[PIX_W-1:0]),
        .word_addr (sc_addr)
    );

    assign accept = (q.st == ST_RUN) && pair_valid && !clear_start;

    // The read port serves the update pipeline, or the scan once the frame is closed.
    assign ram_raddr = (q.st == ST_DONE) ? sc_addr : in_addr;

    // The RAM returns pre-write data for the word written one edge earlier; forward it.
    assign upd_base = (q.wb_v && (q.wb_addr == q.s1_addr)) ? q.wb_data : ram_rdata;

    sat_inc #(.CNT_W(CNT_W), .SATURATE(SAT_EN)) u_inc (
        .base   (upd_base),
        .step   (q.s1_step),
        .result (upd_value)
    );

    always_comb begin
        if (q.st == ST_CLEAR) begin
            ram_we    = 1'b1;
            ram_waddr = q.clr_addr;
            ram_wdata = '0;
        end else begin
            ram_we    = q.s1_v;
            ram_waddr = q.s1_addr;
            ram_wdata = upd_value;
        end
    end

    glcm_count_ram #(.AW(AW), .DW(CNT_W)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .waddr (ram_waddr),
        .wdata (ram_wdata),
        .raddr (ram_raddr),
        .rdata (ram_rdata)
    );

    // Next-state logic.
    always_comb begin
        d = q;

        d.s1_v    = accept;
        d.s1_addr = in_addr;
        d.s1_step = (pair_i == pair_j) ? STEP_DIAG : STEP_OFFDIAG;

        d.wb_v    = q.s1_v && (q.st != ST_CLEAR);
        d.wb_addr = q.s1_addr;
        d.wb_data = upd_value;

        unique case (q.st)
            ST_CLEAR: begin
                d.wb_v     = 1'b0;
                d.clr_addr = q.clr_addr + AW'(1);
                if (q.clr_addr == LAST_ADDR) begin
                    d.st = ST_RUN;
                end
            end
            ST_RUN: begin
                if (accept) begin
                    d.total = q.total + TOT_STEP;
                end
                if (frame_done && !clear_start) begin
                    d.st = ST_FLUSH;
                end
            end
            ST_FLUSH: begin
                d.st = ST_DONE;
            end
            ST_DONE: begin
                d.st = ST_DONE;
            end
            default: begin
                d.st = ST_CLEAR;
            end
        endcase

        if (clear_start && (q.st != ST_CLEAR)) begin
            d.st       = ST_CLEAR;
            d.clr_addr = '0;
            d.total    = '0;
            d.s1_v     = 1'b0;
            d.wb_v     = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st       <= ST_CLEAR;
            q.clr_addr <= '0;
            q.s1_v     <= 1'b0;
            q.s1_addr  <= '0;
            q.s1_step  <= '0;
            q.wb_v     <= 1'b0;
            q.wb_addr  <= '0;
            q.wb_data  <= '0;
            q.total    <= '0;
        end else begin
            q <= d;
        end
    end

    assign ready       = (q.st == ST_RUN);
    assign busy        = (q.st == ST_CLEAR);
    assign scan_ok     = (q.st == ST_DONE);
    assign scan_data   = ram_rdata;
    assign total_count = q.total;

endmodule

// File: rtl/glcm_sym_accum_chk.sv
module glcm_sym_accum_chk #(
    parameter int TOT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_start,
    input logic             pair_valid,
    input logic             frame_done,
    input logic             ready,
    input logic             busy,
    input logic             scan_ok,
    input logic [TOT_W-1:0] total_count
);
    assert_status_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ready, busy, scan_ok}));

    assert_clear_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ready);

    assert_total_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && pair_valid && !clear_start) |=> total_count == $past(total_count) + TOT_W'(2));

    assert_ignore_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ready && !clear_start) |=> $stable(total_count));

    assert_flush_seq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && frame_done && !clear_start) |=> (!ready && !scan_ok) ##1 scan_ok);

    assert_clear_total_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> total_count == '0);
endmodule

bind glcm_sym_accum glcm_sym_accum_chk #(.TOT_W(TOT_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_start (clear_start),
    .pair_valid  (pair_valid),
    .frame_done  (frame_done),
    .ready       (ready),
    .busy        (busy),
    .scan_ok     (scan_ok),
    .total_count (total_count)
);

// File: tb/glcm_sym_accum_tb.sv
module glcm_sym_accum_tb;
    localparam int PIX_W = 6;
    localparam int CNT_W = 16;
    localparam int TOT_W = 32;
    localparam int N     = 1 << PIX_W;
    localparam int DEPTH = N * N;
    localparam int MAXC  = (1 << CNT_W) - 1;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               clear_start = 1'b0;
    logic               pair_valid = 1'b0;
    logic [PIX_W-1:0]   pair_i = '0;
    logic [PIX_W-1:0]   pair_j = '0;
    logic               frame_done = 1'b0;
    logic [2*PIX_W-1:0] scan_addr = '0;
    logic               ready, busy, scan_ok;
    logic [CNT_W-1:0]   scan_data;
    logic [TOT_W-1:0]   total_count;

    int checks = 0;
    int fails  = 0;
    int unsigned model [DEPTH];
    longint unsigned tot_exp = 0;
    bit done_flag = 0;

    always #10 clk = ~clk;

    glcm_sym_accum #(.PIX_W(PIX_W), .CNT_W(CNT_W), .TOT_W(TOT_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .clear_start(clear_start), .pair_valid(pair_valid),
        .pair_i(pair_i), .pair_j(pair_j), .frame_done(frame_done), .scan_addr(scan_addr),
        .ready(ready), .busy(busy), .scan_ok(scan_ok), .scan_data(scan_data),
        .total_count(total_count)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic void model_clear();
        for (int k = 0; k < DEPTH; k++) model[k] = 0;
        tot_exp = 0;
    endfunction

    function automatic int unsigned sat_add(input int unsigned v, input int unsigned s);
        return (v + s > MAXC) ? MAXC : v + s;
    endfunction

    function automatic void model_pair(input int a, input int b);
        if (a == b) begin
            model[a*N+b] = sat_add(model[a*N+b], 2);
        end else begin
            model[a*N+b] = sat_add(model[a*N+b], 1);
            model[b*N+a] = sat_add(model[b*N+a], 1);
        end
        tot_exp += 2;
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic drive(input bit v, input int a, input int b, input bit fd);
        pair_valid = v;
        pair_i     = PIX_W'(a);
        pair_j     = PIX_W'(b);
        frame_done = fd;
        if (ready && v && !clear_start) model_pair(a, b);
        @(posedge clk);
        @(negedge clk);
        pair_valid = 1'b0;
        frame_done = 1'b0;
    endtask

    task automatic scan_one(input int r, input int c, input string req);
        scan_addr = {PIX_W'(r), PIX_W'(c)};
        @(posedge clk);
        @(negedge clk);
        check(scan_data == CNT_W'(model[r*N+c]), req, scan_data, model[r*N+c]);
    endtask

    task automatic wait_clear(input string req);
        int n = 0;
        while (!ready && n < DEPTH + 10) begin
            drive(1'b1, $urandom % N, $urandom % N, 1'b0); // R7: ignored while busy
            n++;
        end
        check(n == DEPTH, req, n, DEPTH);
        check(total_count == 0, "R7", total_count, 0);
    endtask

    task automatic end_frame();
        drive(1'b1, 1, 2, 1'b1);
        check(!ready && !scan_ok, "R8", {ready, scan_ok}, 0);
        drive(1'b1, 3, 3, 1'b0);  // R7: flush cycle ignores pairs
        check(scan_ok == 1'b1, "R8", scan_ok, 1);
        check(total_count == TOT_W'(tot_exp), "R8", total_count, tot_exp);
    endtask

    initial begin
        int unsigned seed_v = $urandom(32'h5eed_1234);
        seed_v = seed_v;
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(busy && !ready && !scan_ok, "R1", {busy, ready, scan_ok}, 3'b100);
        rst_n = 1'b1;
        wait_clear("R1");

        // Directed symmetric and diagonal cases
        drive(1'b1, 3, 7, 1'b0);
        check(total_count == TOT_W'(tot_exp), "R6", total_count, tot_exp);
        drive(1'b1, 7, 3, 1'b0);
        drive(1'b1, 5, 5, 1'b0);
        check(total_count == TOT_W'(tot_exp), "R6", total_count, tot_exp);
        for (int k = 0; k < 4; k++) drive(1'b1, 2, 9, 1'b0);   // R4 back-to-back
        for (int k = 0; k < 3; k++) drive(1'b1, 9, 2, 1'b0);
        drive(1'b1, 63, 0, 1'b0);
        // Random, narrow range for frequent hazards, mixed with gaps
        for (int k = 0; k < 3000; k++) begin
            int a = (k < 1500) ? ($urandom % 6) : ($urandom % N);
            int b = (k < 1500) ? ($urandom % 6) : ($urandom % N);
            drive(($urandom % 4) != 0, a, b, 1'b0);
        end
        check(total_count == TOT_W'(tot_exp), "R6", total_count, tot_exp);
        end_frame();
        drive(1'b1, 4, 4, 1'b0);  // R7: scan phase ignores pairs
        check(total_count == TOT_W'(tot_exp), "R7", total_count, tot_exp);

        scan_one(3, 7, "R2");
        scan_one(7, 3, "R2");
        scan_one(5, 5, "R3");
        scan_one(2, 9, "R4");
        scan_one(63, 0, "R11");
        for (int r = 0; r < N; r++)
            for (int c = 0; c < N; c++)
                scan_one(r, c, "R9");

        // New frame: clear, then saturate a diagonal entry
        clear_start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        clear_start = 1'b0;
        check(busy && total_count == 0, "R10", total_count, 0);
        model_clear();
        wait_clear("R10");
        for (int k = 0; k < 32773; k++) drive(1'b1, 5, 5, 1'b0);
        drive(1'b1, 5, 6, 1'b0);
        end_frame();
        scan_one(5, 5, "R5");
        scan_one(6, 5, "R2");
        scan_one(3, 7, "R10");
        scan_one(0, 0, "R10");
        check(total_count == TOT_W'(tot_exp), "R6", total_count, tot_exp);

        done_flag = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual cycles %0d expected fewer", 190000);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule